// File: doc/BRIEF.md
# Two-Beat Address Tenure Sequencer

This block is the address-phase master for I/O-style transfers on a shared 32-bit address bus. A client hands it a request made of a control/tag word and a physical address through a ready/valid handshake. Once a qualified bus grant arrives, the block runs one tenure. It drives the control/tag word as the first beat together with a one-cycle start strobe. On the next cycle it drives the physical address as the second beat. It holds that beat until the target acknowledges, and on the cycle after the acknowledge it drops its output enable so the bus can float.

Each address byte has its own odd-parity line, driven with the beat it covers. The block does not arbitrate for the bus, move data, or handle retries. It only sequences the address packets and their parity.

Top module: `addr_tenure_drv`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `xfer_start` and `bus_oe` are 0.
- R2: `req_ready` is 1 only while idle. A request is captured on a clock edge where both `req_valid` and `req_ready` are 1. Any `req_valid` while busy is ignored, and the captured words remain the ones driven.
- R3: In the cycle after a clock edge that sees `bus_grant` high while a request is pending, the block drives beat 0. In that cycle `xfer_start` is 1, `bus_oe` is 1 and `bus_addr` equals the captured control/tag word.
- R4: `xfer_start` is 1 for exactly one cycle per tenure, the beat-0 cycle.
- R5: The cycle after beat 0 drives beat 1. In that cycle `bus_addr` equals the captured physical address and `bus_oe` is 1.
- R6: Beat 1 stays on the bus, unchanged, until an edge sees `addr_ack` high. An `addr_ack` seen during beat 0 has no effect.
- R7: In the cycle after an edge that sees `addr_ack` high during beat 1, `bus_oe` is 0 and `req_ready` is 1.
- R8: While `bus_oe` is 1, `bus_par[k]` is odd parity over `bus_addr[8k+7:8k]`. The count of ones in the byte plus its parity bit is odd, so `bus_par[3]` covers the most significant byte.
- R9: `bus_grant` has no effect unless a request is pending. A grant while idle produces no strobe and no enabled bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_ctrl | input | 32 | Control/tag word for beat 0 |
| req_addr | input | 32 | Physical address for beat 1 |
| bus_grant | input | 1 | Qualified address-bus grant |
| addr_ack | input | 1 | Address acknowledge from the target |
| xfer_start | output | 1 | Start-of-tenure strobe |
| bus_addr | output | 32 | Address bus value |
| bus_par | output | 4 | Odd parity, one bit per address byte |
| bus_oe | output | 1 | Output enable for address and parity lines |

## Verification
Assertions check the cycle-level sequencing rules on every cycle. These are: the strobe lasting one cycle, beat 0 following a grant taken while pending, beat 1 following beat 0, beat 1 staying stable until acknowledged, release after the acknowledge, and readiness only while the bus is not driven. Only the bench scenarios can show the data-dependent results. These are that the captured control and address words appear on the right beats, that busy-time requests and early acknowledges leave them untouched, that each parity bit has the correct value for random bytes, and that a grant seen while idle does nothing.

// File: rtl/addr_tenure_pkg.sv
package addr_tenure_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_BT0  = 2'd2,
      ST_BT1  = 2'd3
   } tenure_st_e;
endpackage

// File: rtl/byte_odd_parity.sv
module byte_odd_parity #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   localparam int NB    = DATA_W / BYTE_W
) (
   input  logic [DATA_W-1:0] din,
   output logic [NB-1:0]     par
);
   for (genvar k = 0; k < NB; k++) begin : g_byte
      assign par[k] = ~(^din[k*BYTE_W +: BYTE_W]);
   end
endmodule

// File: rtl/tenure_seq.sv
module tenure_seq
   import addr_tenure_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       bus_grant,
   input  logic       addr_ack,
   output logic       req_ready,
   output logic       cap_en,
   output tenure_st_e st_d,
   output logic       xfer_start,
   output logic       bus_oe
);
   tenure_st_e st_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (req_valid) st_d = ST_PEND;
         ST_PEND: if (bus_grant) st_d = ST_BT0;
         ST_BT0:  st_d = ST_BT1;
         ST_BT1:  if (addr_ack) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign req_ready  = (st_q == ST_IDLE);
   assign cap_en     = req_ready && req_valid;
   assign xfer_start = (st_q == ST_BT0);
   assign bus_oe     = (st_q == ST_BT0) || (st_q == ST_BT1);

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);                                      // R4
   AST_GRANT_TO_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PEND && bus_grant) |=> xfer_start);                   // R3
   AST_BEAT1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> (bus_oe && st_q == ST_BT1));                       // R5
   AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BT1 && addr_ack) |=> (!bus_oe && req_ready));         // R7
   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_oe && !xfer_start));                          // R2
   AST_IDLE_GRANT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> !xfer_start);                       // R9
endmodule

// File: rtl/beat_drive.sv
module beat_drive
   import addr_tenure_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BYTE_W    = 8,
   parameter bit REG_PAR   = 1'b1,
   localparam int NB       = ADDR_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [ADDR_W-1:0] cap_ctrl,
   input  logic [ADDR_W-1:0] cap_addr,
   input  tenure_st_e        st_d,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [NB-1:0]     bus_par
);
   logic [ADDR_W-1:0] ctrl_q, addr_q, bus_d, bus_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         addr_q <= '0;
      end else if (cap_en) begin
         ctrl_q <= cap_ctrl;
         addr_q <= cap_addr;
      end
   end

   always_comb begin
      unique case (st_d)
         ST_BT0:  bus_d = ctrl_q;
         ST_BT1:  bus_d = addr_q;
         default: bus_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_q <= '0;
      else        bus_q <= bus_d;
   end

   assign bus_addr = bus_q;

   if (REG_PAR) begin : g_par_reg
      logic [NB-1:0] par_d, par_q;
      byte_odd_parity #(.DATA_W(ADDR_W), .BYTE_W(BYTE_W)) u_par (
         .din (bus_d),
         .par (par_d)
      );
      always_ff @(posedge clk) begin
         if (!rst_n) par_q <= {NB{1'b1}};
         else        par_q <= par_d;
      end
      assign bus_par = par_q;
   end else begin : g_par_comb
      byte_odd_parity #(.DATA_W(ADDR_W), .BYTE_W(BYTE_W)) u_par (
         .din (bus_q),
         .par (bus_par)
      );
   end
endmodule

// File: rtl/addr_tenure_drv.sv
module addr_tenure_drv
   import addr_tenure_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int BYTE_W  = 8,
   parameter bit REG_PAR = 1'b1,
   localparam int NB     = ADDR_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_ctrl,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              bus_grant,
   input  logic              addr_ack,
   output logic              xfer_start,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [NB-1:0]     bus_par,
   output logic              bus_oe
);
   if (BYTE_W < 1 || ADDR_W % BYTE_W != 0) begin : g_bad_width
      $error("ADDR_W must be a whole number of BYTE_W lanes");
   end

   tenure_st_e st_d;
   logic       cap_en;

   tenure_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .bus_grant  (bus_grant),
      .addr_ack   (addr_ack),
      .req_ready  (req_ready),
      .cap_en     (cap_en),
      .st_d       (st_d),
      .xfer_start (xfer_start),
      .bus_oe     (bus_oe)
   );

   beat_drive #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .REG_PAR(REG_PAR)) u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_ctrl (req_ctrl),
      .cap_addr (req_addr),
      .st_d     (st_d),
      .bus_addr (bus_addr),
      .bus_par  (bus_par)
   );

   AST_BEAT1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !xfer_start && !addr_ack) |=> (bus_oe && $stable(bus_addr))); // R6
   AST_NO_STROBE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> bus_oe);                                                // R3
endmodule

// File: tb/addr_tenure_drv_bench.sv
module addr_tenure_drv_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_ctrl = '0;
   logic [31:0] req_addr = '0;
   logic        bus_grant = 1'b0;
   logic        addr_ack = 1'b0;
   logic        xfer_start;
   logic [31:0] bus_addr;
   logic [3:0]  bus_par;
   logic        bus_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   addr_tenure_drv u_addr_tenure_drv (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ctrl(req_ctrl), .req_addr(req_addr), .bus_grant(bus_grant),
      .addr_ack(addr_ack), .xfer_start(xfer_start), .bus_addr(bus_addr),
      .bus_par(bus_par), .bus_oe(bus_oe)
   );

   function automatic logic [3:0] exp_par(input logic [31:0] a);
      logic [3:0] p;
      for (int k = 0; k < 4; k++) begin
         int ones = 0;
         for (int b = 0; b < 8; b++) ones += a[8*k+b];
         p[k] = (ones % 2 == 0);
      end
      return p;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   task automatic run_tenure(input logic [31:0] c, input logic [31:0] a,
                             input int gd, input int ad, input bit early_ack,
                             input bit busy_req);
      @(negedge clk);
      chk_eq("R2 ready idle", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_ctrl = c; req_addr = a;
      @(negedge clk);
      chk_eq("R2 ready pending", {31'd0, req_ready}, 32'd0);
      req_valid = busy_req; req_ctrl = ~c; req_addr = ~a;
      for (int i = 0; i < gd; i++) begin
         @(negedge clk);
         chk_eq("R9 no start while waiting", {31'd0, xfer_start}, 32'd0);
      end
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0;
      chk_eq("R3 start", {31'd0, xfer_start}, 32'd1);
      chk_eq("R3 oe", {31'd0, bus_oe}, 32'd1);
      chk_eq("R3 beat0 ctrl", bus_addr, c);
      chk_eq("R8 parity beat0", {28'd0, bus_par}, {28'd0, exp_par(c)});
      addr_ack = early_ack;
      @(negedge clk);
      chk_eq("R4 strobe low", {31'd0, xfer_start}, 32'd0);
      chk_eq("R5 beat1 addr", bus_addr, a);
      chk_eq("R6 early ack ignored", {31'd0, bus_oe}, 32'd1);
      chk_eq("R8 parity beat1", {28'd0, bus_par}, {28'd0, exp_par(a)});
      addr_ack = 1'b0;
      for (int i = 0; i < ad; i++) begin
         @(negedge clk);
         chk_eq("R6 held addr", bus_addr, a);
         chk_eq("R6 held oe", {31'd0, bus_oe}, 32'd1);
      end
      addr_ack = 1'b1;
      @(negedge clk);
      addr_ack = 1'b0;
      req_valid = 1'b0;
      chk_eq("R7 released", {31'd0, bus_oe}, 32'd0);
      chk_eq("R7 ready", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      void'($urandom(32'h5eed_0604));
      repeat (3) @(negedge clk);
      chk_eq("R1 ready after reset", {31'd0, req_ready}, 32'd1);
      chk_eq("R1 start after reset", {31'd0, xfer_start}, 32'd0);
      chk_eq("R1 oe after reset", {31'd0, bus_oe}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1 idle after release", {31'd0, req_ready}, 32'd1);

      // R9: grant with nothing pending
      bus_grant = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk_eq("R9 idle grant start", {31'd0, xfer_start}, 32'd0);
         chk_eq("R9 idle grant oe", {31'd0, bus_oe}, 32'd0);
      end
      bus_grant = 1'b0;

      // directed corners
      run_tenure(32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 1'b0, 1'b0);
      run_tenure(32'h8001_7F80, 32'h0101_0101, 2, 3, 1'b1, 1'b1);
      run_tenure(32'hA5A5_5A5A, 32'h1234_5678, 0, 5, 1'b1, 1'b0);

      for (int n = 0; n < 300; n++) begin
         run_tenure($urandom, $urandom, $urandom_range(0, 4), $urandom_range(0, 4),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      done = 1'b1;
      summary();
   end
endmodule